// File: doc/BRIEF.md
# Predicated vector element extractor

This block takes one wide vector operand, a predicate holding one bit per vector byte, and a 32-bit instruction word. It returns a single element of the vector as a scalar. The element size comes from a 2-bit field of the word and can be 8, 16, 32 or 64 bits. The vector length `VL` is a parameter that must be a multiple of 64, so the element count for a given size is `VL` divided by that size.

The block searches the predicate for the highest-numbered active element. A separate mode input then picks either the element after that one, wrapping back to zero, or that element itself. Each mode has its own default for an empty predicate.

The selected element is zero-extended to 64 bits. It is returned together with the decoded destination, source and predicate register indices, one clock after a valid request. A word whose fixed opcode bits do not match raises an illegal-encoding flag instead of a result. Register file access, enable checks and any floating-point meaning of the data are handled elsewhere.

Top module: `vec_elem_pick`

## Requirements
- R1: A word is legal only when bits 31:24 equal 8'h05 and bits 21:13 equal 9'b100010100. A valid request carrying any other word sets `out_illegal` for exactly one cycle, in the following clock, and produces no `out_valid`.
- R2: A valid legal request sets `out_valid` in the next clock only. In that cycle `out_dest` shows word bits 4:0, `out_src` shows bits 9:5 and `out_preg` shows bits 12:10. With `in_valid` low, neither output flag is raised in the next clock.
- R3: The element width is 8 << size, where size is word bits 23:22. The element count is VL divided by that width, and element k occupies vector bits [k*width +: width]. The result is that element zero-extended to 64 bits.
- R4: Element k is active when predicate bit k*(width/8) is set. All other predicate bits of the element's byte group have no effect on the result.
- R5: With `after_mode` = 1 and at least one active element, the element whose index is the highest active index plus one is returned.
- R6: With `after_mode` = 1 and the highest-numbered element active, the index wraps and element 0 is returned.
- R7: With `after_mode` = 1 and no active element, element 0 is returned.
- R8: With `after_mode` = 0 and at least one active element, the highest-numbered active element is returned.
- R9: With `after_mode` = 0 and no active element, the highest-numbered element (count minus one) is returned.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_illegal`, `result`, `out_dest`, `out_src` and `out_preg` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| insn | input | 32 | Instruction word |
| after_mode | input | 1 | 1: element after the last active one; 0: the last active one |
| vec | input | VL | Vector operand |
| pred | input | VL/8 | Predicate, one bit per vector byte |
| out_valid | output | 1 | Result valid, one clock after a legal request |
| out_illegal | output | 1 | The request one clock earlier had an illegal encoding |
| result | output | 64 | Selected element, zero-extended |
| out_dest | output | 5 | Destination register index |
| out_src | output | 5 | Source vector register index |
| out_preg | output | 3 | Governing predicate register index |

## Verification
The assertions check the following on every cycle:
- the handshake timing;
- that the two output flags are exclusive;
- that an illegal word gets a flag and never a result;
- that the decoded indices match the request word of the previous clock;
- that the unused high bits of the result are zero for every element size;
- the empty-predicate defaults of both modes for byte elements.

Other behaviour can only be shown by the bench's scenarios against its reference model:
- the last-active search;
- wraparound in after mode;
- that non-lowest predicate bits are ignored;
- the top-element-only default at larger element sizes.

// File: rtl/vec_elem_pick.sv
module vec_elem_pick #(
  parameter int VL = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     insn,
  input  logic            after_mode,
  input  logic [VL-1:0]   vec,
  input  logic [VL/8-1:0] pred,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [63:0]     result,
  output logic [4:0]      out_dest,
  output logic [4:0]      out_src,
  output logic [2:0]      out_preg
);
  localparam int PW = VL / 8;
  localparam int IW = (PW > 1) ? $clog2(PW) : 1;

  logic       legal;
  logic [1:0] sz;
  logic [63:0] pick_sel;

  assign legal = (insn[31:24] == 8'h05) && (insn[21:13] == 9'b1_0001_0100);
  assign sz    = insn[23:22];

  for (genvar s = 0; s < 4; s++) begin : g_sz
    localparam int ESZ  = 8 << s;
    localparam int NE   = VL / ESZ;
    localparam int STEP = ESZ / 8;

    logic          found;
    logic [IW-1:0] last;
    logic [IW-1:0] sel;
    logic [63:0]   pick;

    always_comb begin
      found = 1'b0;
      last  = '0;
      for (int i = 0; i < NE; i++) begin
        if (pred[i*STEP]) begin
          found = 1'b1;
          last  = IW'(i);
        end
      end
    end

    always_comb begin
      if (after_mode)
        sel = (!found || last == IW'(NE - 1)) ? '0 : last + IW'(1);
      else
        sel = found ? last : IW'(NE - 1);
    end

    assign pick = 64'(vec[int'(sel)*ESZ +: ESZ]);
  end

  always_comb begin
    case (sz)
      2'd0:    pick_sel = g_sz[0].pick;
      2'd1:    pick_sel = g_sz[1].pick;
      2'd2:    pick_sel = g_sz[2].pick;
      default: pick_sel = g_sz[3].pick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      result      <= '0;
      out_dest    <= '0;
      out_src     <= '0;
      out_preg    <= '0;
    end else begin
      out_valid   <= in_valid && legal;
      out_illegal <= in_valid && !legal;
      if (in_valid && legal) begin
        result   <= pick_sel;
        out_dest <= insn[4:0];
        out_src  <= insn[9:5];
        out_preg <= insn[12:10];
      end
    end
  end
endmodule

// File: rtl/vec_elem_pick_chk.sv
module vec_elem_pick_chk #(
  parameter int VL = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [31:0]     insn,
  input logic            after_mode,
  input logic [VL-1:0]   vec,
  input logic [VL/8-1:0] pred,
  input logic            out_valid,
  input logic            out_illegal,
  input logic [63:0]     result,
  input logic [4:0]      out_dest,
  input logic [4:0]      out_src,
  input logic [2:0]      out_preg
);
  logic fixed_ok;
  assign fixed_ok = (insn[31:24] == 8'h05) && (insn[21:13] == 9'b100010100);

  // R1
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !fixed_ok |=> out_illegal && !out_valid);

  // R1
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_valid, out_illegal}));

  // R2
  legal_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && fixed_ok |=> out_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !out_illegal);

  // R2
  index_echo_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_dest == $past(insn[4:0]) && out_src == $past(insn[9:5])
                  && out_preg == $past(insn[12:10]));

  // R3
  zext_byte_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(insn[23:22]) == 2'd0 |-> result[63:8] == 56'd0);

  // R3
  zext_half_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(insn[23:22]) == 2'd1 |-> result[63:16] == 48'd0);

  // R3
  zext_word_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(insn[23:22]) == 2'd2 |-> result[63:32] == 32'd0);

  // R7
  after_empty_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(after_mode) && $past(pred) == '0 && $past(insn[23:22]) == 2'd0
      |-> result == {56'd0, $past(vec[7:0])});

  // R9
  before_empty_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !$past(after_mode) && $past(pred) == '0 && $past(insn[23:22]) == 2'd0
      |-> result == {56'd0, $past(vec[VL-1:VL-8])});
endmodule

bind vec_elem_pick vec_elem_pick_chk #(.VL(VL)) u_chk (.*);

// File: tb/vec_elem_pick_test.sv
`timescale 1ns/1ps
module vec_elem_pick_test;
  localparam int VL = 256;
  localparam int PW = VL / 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [31:0]     insn = '0;
  logic            after_mode = 1'b0;
  logic [VL-1:0]   vec = '0;
  logic [PW-1:0]   pred = '0;
  logic            out_valid, out_illegal;
  logic [63:0]     result;
  logic [4:0]      out_dest, out_src;
  logic [2:0]      out_preg;

  int nchk = 0;
  int nfail = 0;

  typedef struct {
    logic        ill;
    logic [63:0] res;
    logic [4:0]  d;
    logic [4:0]  n;
    logic [2:0]  g;
    string       req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  vec_elem_pick #(.VL(VL)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .after_mode(after_mode),
    .vec(vec), .pred(pred), .out_valid(out_valid), .out_illegal(out_illegal),
    .result(result), .out_dest(out_dest), .out_src(out_src), .out_preg(out_preg)
  );

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic [2:0] g,
                                     input logic [4:0] n, input logic [4:0] d);
    return {8'h05, sz, 9'b100010100, g, n, d};
  endfunction

  function automatic logic [VL-1:0] rvec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [63:0] model(input logic [1:0] sz, input logic m,
                                        input logic [VL-1:0] v, input logic [PW-1:0] p);
    int esz = 8 << sz;
    int ne = VL / esz;
    int last = -1;
    int idx;
    logic [63:0] r = '0;
    for (int i = 0; i < ne; i++) if (p[i*(esz/8)]) last = i;
    if (m) idx = (last < 0 || last + 1 == ne) ? 0 : last + 1;
    else   idx = (last < 0) ? ne - 1 : last;
    for (int b = 0; b < esz; b++) r[b] = v[idx*esz + b];
    return r;
  endfunction

  function automatic logic [PW-1:0] elem_bit(input logic [1:0] sz, input int k);
    logic [PW-1:0] p = '0;
    p[k * (1 << sz)] = 1'b1;
    return p;
  endfunction

  task automatic send(input logic [31:0] w, input logic m, input logic [VL-1:0] v,
                      input logic [PW-1:0] p, input string req);
    exp_t e;
    e.ill = !(w[31:24] == 8'h05 && w[21:13] == 9'b100010100);
    e.res = model(w[23:22], m, v, p);
    e.d = w[4:0];
    e.n = w[9:5];
    e.g = w[12:10];
    e.req = req;
    insn = w; after_mode = m; vec = v; pred = p; in_valid = 1'b1;
    q.push_back(e);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && (out_valid || out_illegal)) begin
      if (q.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R2 unexpected output valid=%0b illegal=%0b expected none", out_valid, out_illegal);
      end else begin
        exp_t e;
        e = q.pop_front();
        nchk++;
        if (e.ill) begin
          if (!out_illegal || out_valid) begin
            nfail++;
            $display("FAIL %s illegal=%0b valid=%0b expected illegal=1 valid=0", e.req, out_illegal, out_valid);
          end
        end else if (!out_valid || out_illegal || result !== e.res || out_dest !== e.d
                     || out_src !== e.n || out_preg !== e.g) begin
          nfail++;
          $display("FAIL %s valid=%0b res=%h d=%0d n=%0d g=%0d expected res=%h d=%0d n=%0d g=%0d",
                   e.req, out_valid, result, out_dest, out_src, out_preg, e.res, e.d, e.n, e.g);
        end
      end
    end
  end

  task automatic check_reset(input string tag);
    nchk++;
    if (out_valid !== 1'b0 || out_illegal !== 1'b0 || result !== '0 || out_dest !== '0
        || out_src !== '0 || out_preg !== '0) begin
      nfail++;
      $display("FAIL %s R10 valid=%0b ill=%0b res=%h d=%0d expected all zero", tag, out_valid,
               out_illegal, result, out_dest);
    end
  endtask

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog expired, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset("start");
    rst = 1'b0;
    @(negedge clk);

    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 2; m++) begin
        int ne = VL / (8 << s);
        logic [1:0] sz = 2'(s);
        logic md = m[0];
        string ra = md ? "R5" : "R8";
        // R7 R9 empty predicate
        send(mk(sz, 3'(s), 5'(m + 3), 5'(s * 7)), md, rvec(), '0, md ? "R7" : "R9");
        // full predicate: after wraps (R6), before takes top (R8)
        send(mk(sz, 3'd7, 5'd31, 5'd1), md, rvec(), '1, md ? "R6" : "R8");
        // top element only
        send(mk(sz, 3'd2, 5'd9, 5'd30), md, rvec(), elem_bit(sz, ne - 1), md ? "R6" : "R8");
        // single element 0 and middle
        send(mk(sz, 3'd0, 5'd0, 5'd0), md, rvec(), elem_bit(sz, 0), ra);
        send(mk(sz, 3'd5, 5'd17, 5'd12), md, rvec(), elem_bit(sz, ne / 2), ra);
        // random predicate, R3 width and zero extension
        send(mk(sz, 3'd3, 5'd4, 5'd5), md, rvec(), PW'({$urandom, $urandom}), "R3");
        if (s > 0) begin
          logic [PW-1:0] junk = '1;
          for (int k = 0; k < ne; k++) junk[k * (1 << s)] = 1'b0;
          // R4 only non-lowest bits set: behaves as empty
          send(mk(sz, 3'd1, 5'd2, 5'd3), md, rvec(), junk, "R4");
          // R4 junk plus element 1 active
          send(mk(sz, 3'd1, 5'd2, 5'd3), md, rvec(), junk | elem_bit(sz, 1), "R4");
        end
      end
    end

    // R1 illegal encodings
    send(mk(2'd0, 3'd0, 5'd0, 5'd0) ^ 32'h0100_0000, 1'b1, rvec(), '1, "R1");
    send(mk(2'd1, 3'd0, 5'd0, 5'd0) ^ 32'h0000_2000, 1'b0, rvec(), '1, "R1");
    send(32'h0, 1'b0, rvec(), '0, "R1");
    send(mk(2'd2, 3'd4, 5'd6, 5'd7), 1'b1, rvec(), elem_bit(2'd2, 3), "R5");

    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    nchk++;
    if (q.size() != 0) begin
      nfail++;
      $display("FAIL R2 missing %0d results expected 0", q.size());
    end

    rst = 1'b1;
    @(negedge clk);
    check_reset("mid");
    rst = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule